// File: doc/BRIEF.md
# Non-Uniform Interpolating Function Table

This block approximates one fixed function over a single bounded input range by linear interpolation between stored sample points. The range is cut into sub-ranges, and each sub-range keeps its own uniform sample grid. Where the function's slope is small the grid is coarse, and where the slope is steep the grid is fine. Because the spacing depends on the sub-range, the block must first decide which sub-range the input falls in. Only then can it form the table address.

An unsigned fixed-point sample enters with a valid strobe, and its interpolated result leaves exactly nine cycles later with its own strobe. A new sample may be offered every cycle. The pipeline works in this order:

- clamp the input to the range;
- select the sub-range by comparing the input with every sub-range start in parallel;
- form the lower and upper table addresses and the fraction;
- read both neighbours from a synchronous-read table;
- interpolate.

The table contents and the sub-range descriptors are fixed at elaboration.

Top module: `seg_interp_top`

## Requirements
- R1: An input below 256 gives the same result as the input 256. For example, input 0 gives 256.
- R2: An input above 3839 gives the same result as the input 3839, which is 57570.
- R3: The sub-range used is the one with the largest start not above the clamped input. The descriptors are (start, step exponent): (256,7), (1280,6), (2304,5), (3328,4). Each sub-range spans up to the next start, and the last one spans up to 3840.
- R4: The breakpoint at grid point x holds (x*x)>>8, truncated. A sub-range with start s and exponent e has breakpoints at s + k·2^e. This includes the closing point at the sub-range's end.
- R5: Let x be the clamped input, s the start and e the exponent of its sub-range. Then off = x − s, k = off>>e and the fraction is the low e bits of off. The result is y0 + ((y1 − y0)·fraction + 2^(e−1)) >> e, where y0 and y1 are breakpoints k and k+1 and the shift is arithmetic. The result is truncated to 16 bits.
- R6: An input that lies exactly on a breakpoint returns that breakpoint's stored value unchanged. For example, 1280 gives 6400 and 2304 gives 20736.
- R7: out_valid goes high exactly 9 rising edges after the edge that captures an input with in_valid high. Inputs on consecutive cycles give results on consecutive cycles, in the same order.
- R8: A synchronous reset clears every in-flight valid bit and sets out_y to 0. No result appears for inputs captured before or during reset.
- R9: While out_valid is low, out_y keeps the last result.
- R10: Every result lies between 256 and 57600 inclusive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_x | input | 12 | Unsigned input sample |
| out_valid | output | 1 | Result strobe, 9 cycles after the input |
| out_y | output | 16 | Interpolated result |

## Verification
Each internal stage has a distinct effect at the ports:

- A wrong sub-range choice or base address returns a breakpoint from another part of the curve. This shows up as a large error exactly nine cycles after the input, most plainly at the sub-range starts and just below them.
- A mistake in the fraction or in rounding gives errors of a few counts only between breakpoints. Inputs that sit on a breakpoint still come out exact.
- A misaligned valid chain or sideband register makes the strobe or the data appear one cycle early or late. In a back-to-back stream this pairs each result with its neighbour's input on the very first output.
- An incomplete reset surfaces as a stray strobe within nine cycles after reset is released.

// File: rtl/seg_interp_pkg.sv
package seg_interp_pkg;

    localparam int XW    = 12;
    localparam int YW    = 16;
    localparam int NSEG  = 4;
    localparam int LAT   = 9;
    localparam int X_LO  = 256;
    localparam int X_HI  = 3839;

    localparam int SEG_START [NSEG] = '{256, 1280, 2304, 3328};
    localparam int SEG_EXP   [NSEG] = '{7, 6, 5, 4};

    // exclusive end of a sub-range
    function automatic int seg_end(input int s);
        if (s >= NSEG - 1) return X_HI + 1;
        return SEG_START[s + 1];
    endfunction

    // entries per sub-range, closing breakpoint included
    function automatic int seg_len(input int s);
        return ((seg_end(s) - SEG_START[s]) >> SEG_EXP[s]) + 1;
    endfunction

    function automatic int seg_base(input int s);
        int acc;
        acc = 0;
        for (int k = 0; k < s; k++) acc += seg_len(k);
        return acc;
    endfunction

    function automatic int max_exp();
        int m;
        m = 1;
        for (int k = 0; k < NSEG; k++) if (SEG_EXP[k] > m) m = SEG_EXP[k];
        return m;
    endfunction

    localparam int DEPTH  = seg_base(NSEG);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int FRAC_W = max_exp();
    localparam int EXP_W  = $clog2(FRAC_W + 1);
    localparam int SEL_W  = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int PW     = YW + FRAC_W + 2;

    function automatic int curve_at(input int x);
        return (x * x) >> 8;
    endfunction

    // grid point belonging to a table entry
    function automatic int grid_x(input int addr);
        int x;
        x = 0;
        for (int s = 0; s < NSEG; s++)
            if (addr >= seg_base(s))
                x = SEG_START[s] + ((addr - seg_base(s)) << SEG_EXP[s]);
        return x;
    endfunction

endpackage

// File: rtl/seg_select.sv
module seg_select
    import seg_interp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [XW-1:0]     x_i,
    output logic [ADDR_W-1:0] lo_addr_o,
    output logic [ADDR_W-1:0] hi_addr_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W-1:0]  ex_o
);

    typedef struct packed {
        logic [XW-1:0]     xc;     // stage 1: clamped input
        logic [XW-1:0]     xs;     // stage 2: input alongside selection
        logic [SEL_W-1:0]  seg;    // stage 2: chosen sub-range
        logic [ADDR_W-1:0] lo;     // stage 3
        logic [ADDR_W-1:0] hi;
        logic [FRAC_W-1:0] frac;
        logic [EXP_W-1:0]  ex;
    } sel_t;

    sel_t sel_d, sel_q;

    logic [NSEG-1:0]   ge;
    logic [XW-1:0]     start;
    logic [XW-1:0]     off;
    logic [XW-1:0]     idx;
    logic [EXP_W-1:0]  ex;
    logic [ADDR_W-1:0] base;

    always_comb begin
        sel_d = sel_q;

        if (x_i < XW'(X_LO))      sel_d.xc = XW'(X_LO);
        else if (x_i > XW'(X_HI)) sel_d.xc = XW'(X_HI);
        else                      sel_d.xc = x_i;

        for (int s = 0; s < NSEG; s++) ge[s] = (sel_q.xc >= XW'(SEG_START[s]));
        sel_d.seg = '0;
        for (int s = 0; s < NSEG; s++) if (ge[s]) sel_d.seg = SEL_W'(s);
        sel_d.xs = sel_q.xc;

        start = '0;
        ex    = '0;
        base  = '0;
        for (int s = 0; s < NSEG; s++) begin
            if (sel_q.seg == SEL_W'(s)) begin
                start = XW'(SEG_START[s]);
                ex    = EXP_W'(SEG_EXP[s]);
                base  = ADDR_W'(seg_base(s));
            end
        end
        off         = sel_q.xs - start;
        idx         = off >> ex;
        sel_d.ex    = ex;
        sel_d.frac  = FRAC_W'(off & ((XW'(1) << ex) - XW'(1)));
        sel_d.lo    = base + ADDR_W'(idx);
        sel_d.hi    = base + ADDR_W'(idx) + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) sel_q <= '0;
        else     sel_q <= sel_d;
    end

    assign lo_addr_o = sel_q.lo;
    assign hi_addr_o = sel_q.hi;
    assign frac_o    = sel_q.frac;
    assign ex_o      = sel_q.ex;

endmodule

// File: rtl/seg_rom.sv
module seg_rom
    import seg_interp_pkg::*;
(
    input  logic              clk,
    input  logic [ADDR_W-1:0] lo_addr_i,
    input  logic [ADDR_W-1:0] hi_addr_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [EXP_W-1:0]  ex_i,
    output logic [YW-1:0]     lo_y_o,
    output logic [YW-1:0]     hi_y_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic [EXP_W-1:0]  ex_o
);

    typedef struct packed {
        logic [YW-1:0]     lo_y;
        logic [YW-1:0]     hi_y;
        logic [FRAC_W-1:0] frac;
        logic [EXP_W-1:0]  ex;
    } rd_t;

    logic [YW-1:0] mem [DEPTH];

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = YW'(curve_at(grid_x(a)));
    end

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d.lo_y = mem[lo_addr_i];
        rd_d.hi_y = mem[hi_addr_i];
        rd_d.frac = frac_i;
        rd_d.ex   = ex_i;
    end

    // registered read port, no reset as in block memory
    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign lo_y_o = rd_q.lo_y;
    assign hi_y_o = rd_q.hi_y;
    assign frac_o = rd_q.frac;
    assign ex_o   = rd_q.ex;

endmodule

// File: rtl/seg_lerp.sv
module seg_lerp
    import seg_interp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [YW-1:0]     lo_y_i,
    input  logic [YW-1:0]     hi_y_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [EXP_W-1:0]  ex_i,
    input  logic              load_i,
    output logic [YW-1:0]     y_o
);

    typedef struct packed {
        logic [YW:0]       dif;    // stage 5
        logic [YW-1:0]     y0a;
        logic [FRAC_W-1:0] fra;
        logic [EXP_W-1:0]  exa;
        logic [PW-1:0]     prd;    // stage 6
        logic [YW-1:0]     y0b;
        logic [EXP_W-1:0]  exb;
        logic [PW-1:0]     adj;    // stage 7
        logic [YW-1:0]     y0c;
        logic [YW-1:0]     sum;    // stage 8
        logic [YW-1:0]     yo;     // stage 9
    } lerp_t;

    lerp_t lp_d, lp_q;

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] rnd;
    logic signed [PW-1:0] part;

    always_comb begin
        lp_d = lp_q;

        lp_d.dif = {1'b0, hi_y_i} - {1'b0, lo_y_i};
        lp_d.y0a = lo_y_i;
        lp_d.fra = frac_i;
        lp_d.exa = ex_i;

        prod     = PW'($signed(lp_q.dif)) * PW'($signed({1'b0, lp_q.fra}));
        lp_d.prd = prod;
        lp_d.y0b = lp_q.y0a;
        lp_d.exb = lp_q.exa;

        if (lp_q.exb == '0) rnd = '0;
        else                rnd = PW'(1) <<< (lp_q.exb - EXP_W'(1));
        part     = $signed(lp_q.prd) + rnd;
        lp_d.adj = part >>> lp_q.exb;
        lp_d.y0c = lp_q.y0b;

        lp_d.sum = lp_q.y0c + lp_q.adj[YW-1:0];

        lp_d.yo  = load_i ? lp_q.sum : lp_q.yo;
    end

    always_ff @(posedge clk) begin
        if (rst) lp_q <= '0;
        else     lp_q <= lp_d;
    end

    assign y_o = lp_q.yo;

endmodule

// File: rtl/seg_interp_top.sv
module seg_interp_top
    import seg_interp_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [XW-1:0] in_x,
    output logic          out_valid,
    output logic [YW-1:0] out_y
);

    logic [LAT-1:0]    vld_d, vld_q;

    logic [ADDR_W-1:0] lo_addr, hi_addr;
    logic [FRAC_W-1:0] frac3, frac4;
    logic [EXP_W-1:0]  ex3, ex4;
    logic [YW-1:0]     lo_y, hi_y;

    always_comb begin
        vld_d = {vld_q[LAT-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= vld_d;
    end

    seg_select u_sel (
        .clk       (clk),
        .rst       (rst),
        .x_i       (in_x),
        .lo_addr_o (lo_addr),
        .hi_addr_o (hi_addr),
        .frac_o    (frac3),
        .ex_o      (ex3)
    );

    seg_rom u_rom (
        .clk       (clk),
        .lo_addr_i (lo_addr),
        .hi_addr_i (hi_addr),
        .frac_i    (frac3),
        .ex_i      (ex3),
        .lo_y_o    (lo_y),
        .hi_y_o    (hi_y),
        .frac_o    (frac4),
        .ex_o      (ex4)
    );

    seg_lerp u_lerp (
        .clk    (clk),
        .rst    (rst),
        .lo_y_i (lo_y),
        .hi_y_i (hi_y),
        .frac_i (frac4),
        .ex_i   (ex4),
        .load_i (vld_q[LAT-2]),
        .y_o    (out_y)
    );

    assign out_valid = vld_q[LAT-1];

endmodule

// File: rtl/seg_interp_chk.sv
module seg_interp_chk
    import seg_interp_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [YW-1:0] out_y
);

    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                     since_rst <= '0;
        else if (since_rst != CW'(LAT)) since_rst <= since_rst + CW'(1);
    end

    // R7: strobe follows the accepted input by exactly nine edges
    p_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (since_rst == CW'(LAT)) |-> (out_valid == $past(in_valid, 9)));

    // R8: reset empties the pipeline
    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R9: result held between strobes
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_y));

    // R10: results stay inside the curve's range
    p_range_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_y >= YW'(256) && out_y <= YW'(57600)));

endmodule

bind seg_interp_top seg_interp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_y     (out_y)
);

// File: tb/sim_seg_interp_top.sv
module sim_seg_interp_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [11:0] in_x;
    logic        out_valid;
    logic [15:0] out_y;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    seg_interp_top u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

    typedef struct packed {
        int x;
        int e;   // -1: expected value from the reference model
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{0, 256}, '{100, 256}, '{255, 256}, '{256, 256}, '{257, -1},
        '{300, 366}, '{1000, -1}, '{1279, 6391}, '{1280, 6400}, '{1281, -1},
        '{2000, -1}, '{2303, -1}, '{2304, 20736}, '{2400, -1}, '{3327, -1},
        '{3328, 43264}, '{3500, -1}, '{3838, -1}, '{3839, 57570}, '{3840, 57570},
        '{4095, 57570}, '{1792, -1}
    };

    // reference model built from R1..R5
    function automatic int ref_y(input int x);
        int st [4] = '{256, 1280, 2304, 3328};
        int ex [4] = '{7, 6, 5, 4};
        int c, s, off, k, fr, y0, y1, r, g0, g1;
        c = (x < 256) ? 256 : ((x > 3839) ? 3839 : x);
        s = 0;
        for (int i = 0; i < 4; i++) if (c >= st[i]) s = i;
        off = c - st[s];
        k   = off >> ex[s];
        fr  = off & ((1 << ex[s]) - 1);
        g0  = st[s] + (k << ex[s]);
        g1  = st[s] + ((k + 1) << ex[s]);
        y0  = (g0 * g0) >> 8;
        y1  = (g1 * g1) >> 8;
        r   = ((y1 - y0) * fr + (1 << (ex[s] - 1))) >>> ex[s];
        return (y0 + r) & 16'hFFFF;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        int held;
        rst      = 1'b1;
        in_valid = 1'b0;
        in_x     = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check("R8 reset out_valid", int'(out_valid), 0);
        check("R8 reset out_y", int'(out_y), 0);
        rst = 1'b0;

        // back-to-back stream: R1 R2 R3 R4 R5 R6 R7
        for (int j = 0; j < NV + 8; j++) begin
            if (j < NV) begin
                in_valid = 1'b1;
                in_x     = 12'(VEC[j].x);
            end else begin
                in_valid = 1'b0;
            end
            step();
            if (j >= 8) begin
                int e;
                e = (VEC[j-8].e >= 0) ? VEC[j-8].e : ref_y(VEC[j-8].x);
                check("R7 stream strobe", int'(out_valid), 1);
                check("R1/R2/R3/R4/R5/R6 stream value", int'(out_y), e);
            end
        end
        in_valid = 1'b0;

        // idle: R9
        held = int'(out_y);
        for (int k = 0; k < 4; k++) begin
            step();
            check("R9 idle strobe", int'(out_valid), 0);
            check("R9 idle hold", int'(out_y), held);
        end

        // single sample latency: R7, R6
        in_valid = 1'b1;
        in_x     = 12'd1280;
        for (int k = 1; k <= 12; k++) begin
            step();
            in_valid = 1'b0;
            check("R7 single latency", int'(out_valid), (k == 9) ? 1 : 0);
            if (k == 9)  check("R6 breakpoint 1280", int'(out_y), 6400);
            if (k == 11) check("R9 hold after result", int'(out_y), 6400);
        end

        // reset while samples in flight: R8
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1;
            in_x     = 12'd2000;
            step();
        end
        rst = 1'b1;
        step();
        step();
        rst      = 1'b0;
        in_valid = 1'b0;
        check("R8 out_y cleared", int'(out_y), 0);
        for (int k = 0; k < 12; k++) begin
            step();
            check("R8 no stale strobe", int'(out_valid), 0);
        end

        // low clamp directed: R1
        in_valid = 1'b1;
        in_x     = 12'd17;
        for (int k = 1; k <= 9; k++) begin
            step();
            in_valid = 1'b0;
        end
        check("R1 low clamp strobe", int'(out_valid), 1);
        check("R1 low clamp value", int'(out_y), 256);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule